// File: doc/BRIEF.md
# Parallel Word DMA Interface Controller

This block connects a host to a 16-bit parallel port and moves whole words between that port and memory without host involvement. The host sets it up through eight register slots. These hold a data word, a DMA word address split across a low and a high half, a word-count range and an address-modifier code. A control/status word carries three function output latches, three status inputs and the event flags. A write-only command slot fires single-cycle actions and stores nothing.

Memory is reached through a word-wide request/acknowledge port. The block holds one word per request until the memory acknowledges, reports a bus error, or stays silent past a cycle limit. The function-1 latch sets the direction. When it is set, port words go into memory. When it is clear, memory words are loaded into the data register, which drives the port output. The block raises one interrupt for end of transfer and for an external attention edge. An attention edge that arrives while a transfer runs stops the transfer.

Top module: `pwdma_ctrl`

## Requirements
- R1: After reset, and after a control write with bit 15 (master clear) set, every register and flag is zero, interrupts are disabled and the control/status word reads 0x0010 (bit 4 = ready) when the status inputs are low.
- R2: A value written to slot 1 (data) reads back unchanged from slot 1 and appears on `port_dout`.
- R3: Control-write bits 3:1 load the function latches, which drive `fcn_out[2:0]`. `stat_in[2:0]` reads back in status bits 12:10.
- R4: The memory byte address is the word address {slot 3 bits 14:0, slot 2} shifted left by one. It holds still while a request waits. Carries from the low half reach the high half. `mem_am` shows slot 5.
- R5: Slot 4 holds the word count minus one. Exactly that many plus one words are moved. Each acknowledged word adds 2 to the byte address and subtracts 1 from slot 4, so slot 4 reads 0xFFFF after a full transfer.
- R6: A transfer starts only when GO (bit 0) and CYCL (bit 4) are written together, either in the control slot or in the command slot 6. GO alone does nothing. At the end, ready (bit 4) and DMA-done (bit 5) are both set.
- R7: When function latch 1 is set, `port_din` words are written to memory (`mem_we`=1). When it is clear, memory words are read into the data register, so the last word read stays on `port_dout`.
- R8: Command slot 6 reads as zero. Its bits are: 8 clears DMA-done, 9 clears attention, 10 clears parity error, 11 clears interrupt enable, 5 sets interrupt enable, and 2 pulses `fcn_out[1]` high for exactly one cycle.
- R9: `irq` is high while interrupt enable (status bit 0) is set and DMA-done or attention is set. A cycle of `irq_ack` clears the enable.
- R10: A rising edge on `attn_in` sets attention (bit 6) one cycle later. During a transfer the same edge ends the transfer at once and sets DMA-done.
- R11: `mem_err` during a request ends the transfer and sets bus error (bit 8) and DMA-done.
- R12: A request left without acknowledge for ACK_LIMIT cycles ends the transfer and sets timeout (bit 9) and DMA-done. Starting a new transfer clears bits 8 and 9.
- R13: `par_err_in` sets a sticky parity flag (bit 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| host_wr | input | 1 | register write strobe |
| host_addr | input | 3 | register slot select |
| host_wdata | input | 16 | write data |
| host_rdata | output | 16 | read data of the selected slot, combinational |
| irq | output | 1 | interrupt request |
| irq_ack | input | 1 | interrupt acknowledge |
| port_dout | output | 16 | parallel output word (data register) |
| port_din | input | 16 | parallel input word |
| fcn_out | output | 3 | function latches, bit 1 also carries the strobe |
| stat_in | input | 3 | external status inputs |
| attn_in | input | 1 | attention input, edge sensitive |
| par_err_in | input | 1 | parity error report |
| mem_req | output | 1 | memory request |
| mem_we | output | 1 | 1 = write to memory |
| mem_addr | output | 32 | byte address |
| mem_am | output | AM_W | address modifier code |
| mem_wdata | output | 16 | word to memory |
| mem_rdata | input | 16 | word from memory |
| mem_ack | input | 1 | word accepted |
| mem_err | input | 1 | bus error for the request |

## Verification
Register writes take effect at the clock edge that samples the strobe, so the bench reads them back at the following falling edge. A start write puts `mem_req` up at that same edge. A rising edge on `attn_in`, an error response or a final acknowledge shows in the status word one edge after the input is sampled. A command-slot strobe is visible on `fcn_out[1]` for exactly the cycle after the write. The bench drives every input on falling edges and samples there, and it polls ready with a bounded loop for the multi-cycle transfers.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

    localparam int DW  = 16;          // data word width
    localparam int HIW = 15;          // high address half width
    localparam int WAW = DW + HIW;    // word address width
    localparam int BAW = WAW + 1;     // byte address width

    typedef enum logic [2:0] {
        SEL_CSR   = 3'd0,
        SEL_DATA  = 3'd1,
        SEL_ALO   = 3'd2,
        SEL_AHI   = 3'd3,
        SEL_RANGE = 3'd4,
        SEL_AMOD  = 3'd5,
        SEL_PULSE = 3'd6,
        SEL_NONE  = 3'd7
    } sel_e;

    typedef enum logic {
        ST_IDLE,
        ST_XFER
    } st_e;

    typedef struct packed {
        logic       mclr;
        logic       go;
        logic       cycl;
        logic [2:0] fcn;
        logic       ie;
        logic       clr_attf;
    } csrw_t;

    typedef struct packed {
        logic go;
        logic cycl;
        logic fn2_strobe;
        logic ie_set;
        logic ie_clr;
        logic clr_dmaf;
        logic clr_attf;
        logic clr_perr;
    } pulse_t;

    typedef struct packed {
        logic       ie;
        logic [2:0] fcn;
        logic       ready;
        logic       dmaf;
        logic       attf;
        logic       perr;
        logic       berr;
        logic       terr;
        logic [2:0] stat;
    } status_t;

    typedef struct packed {
        logic fin;
        logic berr;
        logic terr;
    } dma_ev_t;

    function automatic csrw_t csr_decode(input logic [DW-1:0] w);
        csrw_t r;
        r.mclr     = w[15];
        r.go       = w[0];
        r.fcn      = w[3:1];
        r.cycl     = w[4];
        r.ie       = w[5];
        r.clr_attf = w[6];
        return r;
    endfunction

    function automatic pulse_t pulse_decode(input logic [DW-1:0] w);
        pulse_t r;
        r.go         = w[0];
        r.fn2_strobe = w[2];
        r.cycl       = w[4];
        r.ie_set     = w[5];
        r.clr_dmaf   = w[8];
        r.clr_attf   = w[9];
        r.clr_perr   = w[10];
        r.ie_clr     = w[11];
        return r;
    endfunction

    function automatic logic [DW-1:0] csr_pack(input status_t s);
        return {3'b000, s.stat, s.terr, s.berr, s.perr, s.attf,
                s.dmaf, s.ready, s.fcn, s.ie};
    endfunction

endpackage

// File: rtl/pwd_decode.sv
module pwd_decode
    import pwd_pkg::*;
(
    input  logic          host_wr,
    input  logic [2:0]    host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic          csr_we,
    output csrw_t         csr_cmd,
    output pulse_t        pls,
    output logic          data_we,
    output logic          alo_we,
    output logic          ahi_we,
    output logic          rng_we,
    output logic          amod_we
);
    sel_e sel;

    always_comb begin
        sel     = sel_e'(host_addr);
        csr_cmd = csr_decode(host_wdata);
        csr_we  = host_wr && (sel == SEL_CSR);
        data_we = host_wr && (sel == SEL_DATA);
        alo_we  = host_wr && (sel == SEL_ALO);
        ahi_we  = host_wr && (sel == SEL_AHI);
        rng_we  = host_wr && (sel == SEL_RANGE);
        amod_we = host_wr && (sel == SEL_AMOD);
        if (host_wr && (sel == SEL_PULSE))
            pls = pulse_decode(host_wdata);
        else
            pls = '0;
    end
endmodule

// File: rtl/pwd_engine.sv
module pwd_engine
    import pwd_pkg::*;
#(
    parameter int ACK_LIMIT = 64
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           start,
    input  logic           dir_in,
    input  logic           abort,
    input  logic           ld_alo,
    input  logic           ld_ahi,
    input  logic           ld_rng,
    input  logic [DW-1:0]  wdata,
    input  logic           mem_ack,
    input  logic           mem_err,
    output logic           busy,
    output logic [DW-1:0]  alo,
    output logic [HIW-1:0] ahi,
    output logic [DW-1:0]  rng,
    output logic           mem_req,
    output logic           mem_we,
    output logic [BAW-1:0] mem_addr,
    output logic           cap,
    output dma_ev_t        ev
);
    localparam int TCW = $clog2(ACK_LIMIT + 1);

    st_e            st;
    logic           dir;
    logic [TCW-1:0] tcnt;
    logic           last;
    logic           expire;

    assign last     = (rng == '0);
    assign expire   = (tcnt == TCW'(ACK_LIMIT - 1));
    assign busy     = (st == ST_XFER);
    assign mem_req  = busy;
    assign mem_we   = dir;
    assign mem_addr = {ahi, alo, 1'b0};

    always_comb begin
        ev  = '0;
        cap = 1'b0;
        if (st == ST_XFER) begin
            if (abort) begin
                ev.fin = 1'b1;
            end else if (mem_err) begin
                ev.fin  = 1'b1;
                ev.berr = 1'b1;
            end else if (mem_ack) begin
                ev.fin = last;
                cap    = !dir;
            end else if (expire) begin
                ev.fin  = 1'b1;
                ev.terr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st   <= ST_IDLE;
            dir  <= 1'b0;
            tcnt <= '0;
            alo  <= '0;
            ahi  <= '0;
            rng  <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (ld_alo) alo <= wdata;
                    if (ld_ahi) ahi <= wdata[HIW-1:0];
                    if (ld_rng) rng <= wdata;
                    if (start) begin
                        st   <= ST_XFER;
                        dir  <= dir_in;
                        tcnt <= '0;
                    end
                end
                ST_XFER: begin
                    if (abort || mem_err) begin
                        st <= ST_IDLE;
                    end else if (mem_ack) begin
                        {ahi, alo} <= {ahi, alo} + WAW'(1);
                        rng        <= rng - 1'b1;
                        tcnt       <= '0;
                        if (last) st <= ST_IDLE;
                    end else if (expire) begin
                        st <= ST_IDLE;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pwdma_ctrl.sv
module pwdma_ctrl
    import pwd_pkg::*;
#(
    parameter int AM_W      = 8,
    parameter int ACK_LIMIT = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            host_wr,
    input  logic [2:0]      host_addr,
    input  logic [15:0]     host_wdata,
    output logic [15:0]     host_rdata,
    output logic            irq,
    input  logic            irq_ack,
    output logic [15:0]     port_dout,
    input  logic [15:0]     port_din,
    output logic [2:0]      fcn_out,
    input  logic [2:0]      stat_in,
    input  logic            attn_in,
    input  logic            par_err_in,
    output logic            mem_req,
    output logic            mem_we,
    output logic [31:0]     mem_addr,
    output logic [AM_W-1:0] mem_am,
    output logic [15:0]     mem_wdata,
    input  logic [15:0]     mem_rdata,
    input  logic            mem_ack,
    input  logic            mem_err
);
    localparam int NFCN = 3;

    logic          csr_we, data_we, alo_we, ahi_we, rng_we, amod_we;
    csrw_t         csr_cmd;
    pulse_t        pls;
    logic          mclr, start, dir_in, busy, cap, attn_rise;
    dma_ev_t       ev;
    logic [DW-1:0]  alo, rng;
    logic [HIW-1:0] ahi;
    logic [DW-1:0]  data_q;
    logic [AM_W-1:0] amod_q;
    logic [NFCN-1:0] fcn_q;
    logic          ie_q, dmaf_q, attf_q, perr_q, berr_q, terr_q;
    logic          strobe_q, attn_q;
    status_t       stat_w;

    pwd_decode u_decode (
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .csr_we     (csr_we),
        .csr_cmd    (csr_cmd),
        .pls        (pls),
        .data_we    (data_we),
        .alo_we     (alo_we),
        .ahi_we     (ahi_we),
        .rng_we     (rng_we),
        .amod_we    (amod_we)
    );

    assign mclr      = csr_we && csr_cmd.mclr;
    assign start     = !mclr && ((csr_we && csr_cmd.go && csr_cmd.cycl) ||
                                 (pls.go && pls.cycl));
    assign dir_in    = csr_we ? csr_cmd.fcn[0] : fcn_q[0];
    assign attn_rise = attn_in && !attn_q;

    pwd_engine #(.ACK_LIMIT(ACK_LIMIT)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .clr      (mclr),
        .start    (start),
        .dir_in   (dir_in),
        .abort    (attn_rise),
        .ld_alo   (alo_we),
        .ld_ahi   (ahi_we),
        .ld_rng   (rng_we),
        .wdata    (host_wdata),
        .mem_ack  (mem_ack),
        .mem_err  (mem_err),
        .busy     (busy),
        .alo      (alo),
        .ahi      (ahi),
        .rng      (rng),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .cap      (cap),
        .ev       (ev)
    );

    always_ff @(posedge clk) begin
        if (rst) attn_q <= 1'b0;
        else     attn_q <= attn_in;
    end

    always_ff @(posedge clk) begin
        if (rst || mclr) begin
            fcn_q    <= '0;
            ie_q     <= 1'b0;
            dmaf_q   <= 1'b0;
            attf_q   <= 1'b0;
            perr_q   <= 1'b0;
            berr_q   <= 1'b0;
            terr_q   <= 1'b0;
            strobe_q <= 1'b0;
            data_q   <= '0;
            amod_q   <= '0;
        end else begin
            strobe_q <= pls.fn2_strobe;
            if (csr_we) begin
                fcn_q <= csr_cmd.fcn;
                ie_q  <= csr_cmd.ie;
            end
            if (pls.ie_set) ie_q <= 1'b1;
            if (pls.ie_clr || irq_ack) ie_q <= 1'b0;

            if (pls.clr_dmaf) dmaf_q <= 1'b0;
            if (ev.fin)       dmaf_q <= 1'b1;

            if (pls.clr_attf || (csr_we && csr_cmd.clr_attf)) attf_q <= 1'b0;
            if (attn_rise) attf_q <= 1'b1;

            if (pls.clr_perr) perr_q <= 1'b0;
            if (par_err_in)   perr_q <= 1'b1;

            if (start && !busy) begin
                berr_q <= 1'b0;
                terr_q <= 1'b0;
            end
            if (ev.berr) berr_q <= 1'b1;
            if (ev.terr) terr_q <= 1'b1;

            if (data_we) data_q <= host_wdata;
            if (cap)     data_q <= mem_rdata;
            if (amod_we) amod_q <= host_wdata[AM_W-1:0];
        end
    end

    for (genvar i = 0; i < NFCN; i++) begin : g_fcn
        if (i == 1) begin : g_strobe
            assign fcn_out[i] = fcn_q[i] | strobe_q;
        end else begin : g_plain
            assign fcn_out[i] = fcn_q[i];
        end
    end

    assign irq       = ie_q && (dmaf_q || attf_q);
    assign port_dout = data_q;
    assign mem_wdata = port_din;
    assign mem_am    = amod_q;

    always_comb begin
        stat_w.ie    = ie_q;
        stat_w.fcn   = fcn_q;
        stat_w.ready = !busy;
        stat_w.dmaf  = dmaf_q;
        stat_w.attf  = attf_q;
        stat_w.perr  = perr_q;
        stat_w.berr  = berr_q;
        stat_w.terr  = terr_q;
        stat_w.stat  = stat_in;
        case (sel_e'(host_addr))
            SEL_CSR:   host_rdata = csr_pack(stat_w);
            SEL_DATA:  host_rdata = data_q;
            SEL_ALO:   host_rdata = alo;
            SEL_AHI:   host_rdata = {1'b0, ahi};
            SEL_RANGE: host_rdata = rng;
            SEL_AMOD:  host_rdata = DW'(amod_q);
            default:   host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pwd_checker.sv
module pwd_checker (
    input logic        clk,
    input logic        rst,
    input logic        host_wr,
    input logic        mem_req,
    input logic        mem_ack,
    input logic        mem_err,
    input logic [31:0] mem_addr,
    input logic        irq,
    input logic        irq_ack,
    input logic        attn_in,
    input logic        attn_q,
    input logic        dmaf_q,
    input logic        attf_q,
    input logic        berr_q
);
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !mem_err && !host_wr) |=> (!mem_req || $stable(mem_addr)));

    p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && !mem_err && !host_wr && !(attn_in && !attn_q))
        |=> (!mem_req || mem_addr == $past(mem_addr) + 32'd2));

    p_ack_drops_ie_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !host_wr) |=> !irq);

    p_attn_flag_r10: assert property (@(posedge clk) disable iff (rst)
        (attn_in && !attn_q && !host_wr) |=> attf_q);

    p_attn_abort_r10: assert property (@(posedge clk) disable iff (rst)
        (attn_in && !attn_q && !host_wr && mem_req) |=> (!mem_req && dmaf_q));

    p_bus_err_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_err && !host_wr && !(attn_in && !attn_q))
        |=> (!mem_req && dmaf_q && berr_q));
endmodule

bind pwdma_ctrl pwd_checker u_pwd_checker (
    .clk      (clk),
    .rst      (rst),
    .host_wr  (host_wr),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_err  (mem_err),
    .mem_addr (mem_addr),
    .irq      (irq),
    .irq_ack  (irq_ack),
    .attn_in  (attn_in),
    .attn_q   (attn_q),
    .dmaf_q   (dmaf_q),
    .attf_q   (attf_q),
    .berr_q   (berr_q)
);

// File: tb/test_pwdma_ctrl.sv
module test_pwdma_ctrl;
    localparam int LIMIT = 32;

    logic        clk = 0;
    logic        rst = 1;
    logic        host_wr = 0;
    logic [2:0]  host_addr = 0;
    logic [15:0] host_wdata = 0;
    logic [15:0] host_rdata;
    logic        irq, irq_ack = 0;
    logic [15:0] port_dout, port_din = 0;
    logic [2:0]  fcn_out;
    logic        attn_drv = 0, par_err_in = 0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_am;
    logic [15:0] mem_wdata, mem_rdata;
    logic        mem_ack = 0, mem_err = 0;
    logic        attn_in;
    logic [2:0]  stat_in;

    int total = 0, bad = 0;
    bit done = 0;

    logic [15:0] mem [256];
    int          lat = 1, mcnt = 0, acks = 0;
    bit          noack = 0, errm = 0;
    logic [31:0] alog [64];

    always #10 clk = ~clk;

    assign attn_in   = fcn_out[1] | attn_drv;
    assign stat_in   = fcn_out;
    assign mem_rdata = mem[mem_addr[8:1]];

    pwdma_ctrl #(.AM_W(8), .ACK_LIMIT(LIMIT)) i_pwdma_ctrl (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
        .irq_ack(irq_ack), .port_dout(port_dout), .port_din(port_din),
        .fcn_out(fcn_out), .stat_in(stat_in), .attn_in(attn_in),
        .par_err_in(par_err_in), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_am(mem_am), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err)
    );

    // memory model: answers a request after lat idle falling edges
    always @(negedge clk) begin
        if (mem_ack || mem_err) begin
            mem_ack = 0;
            mem_err = 0;
            mcnt    = 0;
        end else if (mem_req) begin
            if (mcnt >= lat && !noack) begin
                if (errm) mem_err = 1;
                else begin
                    mem_ack = 1;
                    if (mem_we) mem[mem_addr[8:1]] = mem_wdata;
                    if (acks < 64) alog[acks] = mem_addr;
                    acks++;
                end
            end else mcnt++;
        end else mcnt = 0;
    end

    function automatic logic [15:0] exp_csr(input bit ie, input logic [2:0] f,
        input bit rdy, input bit dmaf, input bit attf, input bit perr,
        input bit berr, input bit terr, input logic [2:0] st);
        return {3'b000, st, terr, berr, perr, attf, dmaf, rdy, f, ie};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_ready();
        logic [15:0] v;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            rd(3'd0, v);
            if (v[4]) break;
        end
    endtask

    task automatic setup_xfer(input int base, input int n);
        wr(3'd6, 16'h0300);
        wr(3'd2, 16'(base));
        wr(3'd3, 16'h0000);
        wr(3'd4, 16'(n - 1));
        acks = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, pat, am;
        int base, n;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 3);
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); chk("R1 csr after reset", v, 16'h0010);
        rd(3'd1, v); chk("R1 data after reset", v, 16'h0000);
        chk("R1 irq after reset", irq, 0);

        // R2 data loopback, random patterns
        for (int i = 0; i < 6; i++) begin
            pat = 16'($urandom);
            wr(3'd1, pat);
            rd(3'd1, v); chk("R2 data readback", v, pat);
            chk("R2 port_dout", port_dout, pat);
        end

        // R3 function latches looped to status inputs
        wr(3'd0, 16'h000A);
        chk("R3 fcn_out F1|F3", fcn_out, 3'b101);
        rd(3'd0, v); chk("R3 status A,C", v[12:10], 3'b101);
        wr(3'd0, 16'h0004);
        rd(3'd0, v); chk("R3 status B", v[12:10], 3'b010);
        wr(3'd0, 16'h0000);
        wr(3'd6, 16'h0300);

        // R6 GO without CYCL does not start
        setup_xfer(20, 4);
        wr(3'd0, 16'h0001);
        @(negedge clk);
        chk("R6 go alone no request", mem_req, 0);
        rd(3'd0, v); chk("R6 go alone stays ready", v[4], 1);

        // R5 R7 R4 memory-to-port transfers
        for (int k = 0; k < 4; k++) begin
            base = 8 + int'($urandom % 150);
            n    = 1 + int'($urandom % 40);
            lat  = int'($urandom % 3);
            am   = 16'($urandom % 256);
            for (int i = 0; i < n; i++) mem[base + i] = 16'($urandom);
            setup_xfer(base, n);
            wr(3'd5, am);
            wr(3'd0, 16'h0011);
            chk("R6 request raised", mem_req, 1);
            chk("R4 address modifier", mem_am, am[7:0]);
            chk("R7 read direction", mem_we, 0);
            wait_ready();
            chk("R5 word count", acks, n);
            chk("R4 first byte address", alog[0], 32'(base * 2));
            rd(3'd1, v); chk("R7 last word in data", v, mem[base + n - 1]);
            chk("R7 last word on port", port_dout, mem[base + n - 1]);
            rd(3'd4, v); chk("R5 range exhausted", v, 16'hFFFF);
            rd(3'd2, v); chk("R5 address advanced", v, 16'(base + n));
            rd(3'd0, v); chk("R6 ready and done", v, exp_csr(0, 0, 1, 1, 0, 0, 0, 0, 0));
        end

        // R7 port-to-memory transfers, one started through the command slot
        for (int k = 0; k < 3; k++) begin
            base = 8 + int'($urandom % 150);
            n    = 1 + int'($urandom % 40);
            lat  = int'($urandom % 3);
            port_din = 16'($urandom);
            mem[base - 1] = 16'hDEAD;
            mem[base + n] = 16'hBEEF;
            setup_xfer(base, n);
            if (k == 0) begin
                wr(3'd0, 16'h0002);
                wr(3'd6, 16'h0011);
            end else wr(3'd0, 16'h0013);
            chk("R7 write direction", mem_we, 1);
            wait_ready();
            chk("R5 words into memory", acks, n);
            for (int i = 0; i < n; i++) chk("R7 memory word", mem[base + i], port_din);
            chk("R5 word before range", mem[base - 1], 16'hDEAD);
            chk("R5 word after range", mem[base + n], 16'hBEEF);
            rd(3'd0, v); chk("R6 done after input", v, exp_csr(0, 3'b001, 1, 1, 0, 0, 0, 0, 3'b001));
        end
        wr(3'd0, 16'h0000);

        // R4 carry from low half into high half
        lat = 0;
        wr(3'd6, 16'h0300);
        wr(3'd2, 16'hFFFF);
        wr(3'd3, 16'h4A5B);
        wr(3'd4, 16'h0001);
        acks = 0;
        wr(3'd0, 16'h0011);
        wait_ready();
        chk("R4 address before carry", alog[0], {15'h4A5B, 16'hFFFF, 1'b0});
        chk("R4 address after carry", alog[1], {15'h4A5C, 16'h0000, 1'b0});
        rd(3'd3, v); chk("R4 high half readback", v, 16'h4A5C);

        // R10 attention ends a running transfer
        lat = 20;
        setup_xfer(40, 30);
        wr(3'd0, 16'h0011);
        repeat (50) @(negedge clk);
        attn_drv = 1;
        @(negedge clk);
        chk("R10 transfer stopped", mem_req, 0);
        rd(3'd0, v);
        chk("R10 done and attention", {v[6], v[5], v[4]}, 3'b111);
        chk("R10 ended early", (acks > 0 && acks < 30), 1);
        attn_drv = 0;

        // R9 interrupt and acknowledge
        wr(3'd0, 16'h0020);
        chk("R9 irq with enable", irq, 1);
        @(negedge clk); irq_ack = 1;
        @(negedge clk); irq_ack = 0;
        chk("R9 ack drops irq", irq, 0);
        rd(3'd0, v); chk("R9 ack clears enable keeps flags", {v[6], v[5], v[0]}, 3'b110);

        // R8 command slot actions
        rd(3'd6, v); chk("R8 command slot reads zero", v, 16'h0000);
        wr(3'd6, 16'h0020);
        chk("R8 set enable", irq, 1);
        wr(3'd6, 16'h0800);
        chk("R8 mask clear", irq, 0);
        wr(3'd6, 16'h0100);
        rd(3'd0, v); chk("R8 clear done only", {v[6], v[5]}, 2'b10);
        wr(3'd6, 16'h0200);
        rd(3'd0, v); chk("R8 clear attention", v[6], 0);
        wr(3'd6, 16'h0020);
        chk("R9 no flags no irq", irq, 0);
        wr(3'd6, 16'h0004);
        chk("R8 strobe high", fcn_out[1], 1);
        @(negedge clk);
        chk("R8 strobe one cycle", fcn_out[1], 0);
        rd(3'd0, v); chk("R10 strobe loops to attention", v[6], 1);
        chk("R9 attention irq", irq, 1);
        wr(3'd6, 16'h0A00);

        // R11 bus error
        lat = 1; errm = 1;
        setup_xfer(60, 5);
        wr(3'd0, 16'h0011);
        wait_ready();
        errm = 0;
        rd(3'd0, v); chk("R11 bus error status", v, exp_csr(0, 0, 1, 1, 0, 0, 1, 0, 0));
        chk("R11 no word moved", acks, 0);

        // R12 timeout, and fresh start clears the error bits
        noack = 1;
        setup_xfer(60, 5);
        wr(3'd0, 16'h0011);
        repeat (10) @(negedge clk);
        rd(3'd0, v); chk("R12 still waiting", {v[9], v[8], v[4]}, 3'b000);
        wait_ready();
        noack = 0;
        rd(3'd0, v); chk("R12 timeout status", v, exp_csr(0, 0, 1, 1, 0, 0, 0, 1, 0));

        // R13 parity flag and its clear
        @(negedge clk); par_err_in = 1;
        @(negedge clk); par_err_in = 0;
        repeat (2) @(negedge clk);
        rd(3'd0, v); chk("R13 parity sticky", v[7], 1);
        wr(3'd6, 16'h0400);
        rd(3'd0, v); chk("R8 parity clear", v[7], 0);

        // R1 master clear
        wr(3'd1, 16'h5A5A);
        wr(3'd0, 16'h002E);
        wr(3'd0, 16'h8000);
        rd(3'd0, v); chk("R1 csr after master clear", v, 16'h0010);
        rd(3'd1, v); chk("R1 data after master clear", v, 16'h0000);
        rd(3'd2, v); chk("R1 address after master clear", v, 16'h0000);
        chk("R1 fcn after master clear", fcn_out, 3'b000);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule